// File: doc/BRIEF.md
# Output Drive Gating with Protection Override

This block turns a latched eight-bit switch command into eight registered gate-enable signals for a bank of power switches. Two of the channels also take a direct pulse-width input, which is ORed with their command bit so that a timer can switch the load without a serial write. A set of protection conditions sits on top of the command. Some are global: the enable pin, supply overvoltage and logic-supply undervoltage. One is per channel: a thermal-limit flag.

None of these shutdowns destroys the command, except undervoltage. While a condition holds, the affected outputs are forced off. When it clears, each output returns to whatever its command says at that moment. Undervoltage behaves like a reset of the command register, so the outputs stay off after recovery until a new command is loaded. A thermally limited channel reports a status bit, and that channel alone restarts by itself each time its flag drops.

All protection and direct inputs are asynchronous levels, already debounced upstream. Each passes through a two-flop synchronizer before use. The command arrives synchronously with a one-cycle load strobe.

Top module: `out_gate`

## Requirements
- R1: After reset, `drive_o` and `otemp_flt_o` are all zero.
- R2: A cycle with `cmd_load_i` high captures `cmd_i`. Bit i of the captured command drives `drive_o[i]`, so bit 0 is the first output and bit 7 is the eighth. The value is held until the next load.
- R3: `drive_o[4]` is command bit 4 OR `pwm_i[0]`, and `drive_o[5]` is command bit 5 OR `pwm_i[1]`. The direct inputs have no effect on any other channel.
- R4: While `en_i` is low, all outputs are off. When it returns high, the outputs follow the latched command again with no new load.
- R5: While `ov_i` is high, all outputs are off. When it clears, each output resumes its current command, including a command loaded during the overvoltage.
- R6: While `uv_i` is high, all outputs and all fault bits are zero, the command register is cleared and loads are ignored. After recovery the commanded outputs stay off until a new load.
- R7: `therm_i[i]` high turns off `drive_o[i]` only. The other channels are unaffected.
- R8: When `therm_i[i]` clears, `drive_o[i]` turns back on if its command is still on, and stays off if the command was changed to off. This repeats for each assertion of the flag.
- R9: `otemp_flt_o[i]` is 1 while `therm_i[i]` is high, unless undervoltage is present.
- R10: A change on `cmd_i` with `cmd_load_i` reaches `drive_o` at the second rising edge after it is sampled. A change on an asynchronous input reaches the outputs at the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 8 | Switch command, one bit per channel |
| cmd_load_i | input | 1 | Single-cycle strobe that latches `cmd_i` |
| pwm_i | input | 2 | Direct switch inputs for channels 4 and 5 (zero-based) |
| en_i | input | 1 | Output enable, asynchronous, active high |
| ov_i | input | 1 | Supply overvoltage flag, asynchronous |
| uv_i | input | 1 | Logic-supply undervoltage flag, asynchronous |
| therm_i | input | 8 | Per-channel thermal-limit flags, asynchronous |
| drive_o | output | 8 | Registered gate-enable per channel |
| otemp_flt_o | output | 8 | Registered per-channel overtemperature status |

## Verification
The hardest case to reach is a command that changes while an output is held off, because the ports then show no trace of the change. One example is a new load during overvoltage. Another is a command switched off while a channel's thermal flag is still high. The stimulus loads the new command inside the shutdown window and then releases the condition. The outputs then show whether the latched state or a stale copy came back. The thermal flag is set and cleared twice on the same channel to show that the restart repeats. A load is also issued during undervoltage, and the bench confirms that the channel stays dark after recovery.

// File: rtl/out_gate_pkg.sv
package out_gate_pkg;
  typedef struct packed {
    logic enable;
    logic overvolt;
    logic undervolt;
  } glob_cond_t;

  localparam int GLOB_W = $bits(glob_cond_t);

  function automatic logic glob_permit(glob_cond_t c);
    return c.enable & ~c.overvolt & ~c.undervolt;
  endfunction
endpackage

// File: rtl/og_sync.sv
module og_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/og_cmd_reg.sv
module og_cmd_reg #(
  parameter int N_CH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            load_i,
  input  logic [N_CH-1:0] cmd_i,
  output logic [N_CH-1:0] cmd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_o <= '0;
    else if (clr_i)  cmd_o <= '0;   // undervoltage acts as sync reset, wins over load
    else if (load_i) cmd_o <= cmd_i;
  end

  assert_uv_clears_cmd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cmd_o == '0);
  assert_cmd_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !clr_i) |=> $stable(cmd_o));
endmodule

// File: rtl/og_channel.sv
module og_channel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic therm_i,
  input  logic permit_i,
  input  logic uv_i,
  output logic drive_o,
  output logic flt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drive_o <= 1'b0;
      flt_o   <= 1'b0;
    end else begin
      drive_o <= req_i & permit_i & ~therm_i;
      flt_o   <= therm_i & ~uv_i;
    end
  end

  assert_therm_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    therm_i |=> !drive_o);
  assert_therm_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (therm_i && !uv_i) |=> flt_o);
  assert_uv_no_flt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |=> !flt_o);
endmodule

// File: rtl/out_gate.sv
module out_gate
  import out_gate_pkg::*;
#(
  parameter int N_CH        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PWM_CH_A    = 4,
  parameter int PWM_CH_B    = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] cmd_i,
  input  logic            cmd_load_i,
  input  logic [1:0]      pwm_i,
  input  logic            en_i,
  input  logic            ov_i,
  input  logic            uv_i,
  input  logic [N_CH-1:0] therm_i,
  output logic [N_CH-1:0] drive_o,
  output logic [N_CH-1:0] otemp_flt_o
);
  localparam int ASYNC_W = N_CH + 2 + GLOB_W;

  logic [ASYNC_W-1:0] async_s;
  logic [N_CH-1:0]    therm_s;
  logic [1:0]         pwm_s;
  glob_cond_t         glob_s;
  logic               permit;
  logic [N_CH-1:0]    cmd_q;
  logic [N_CH-1:0]    req;

  og_sync #(.WIDTH(ASYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({therm_i, pwm_i, en_i, ov_i, uv_i}),
    .q_o   (async_s)
  );

  assign {therm_s, pwm_s, glob_s} = async_s;
  assign permit = glob_permit(glob_s);

  og_cmd_reg #(.N_CH(N_CH)) u_cmd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (glob_s.undervolt),
    .load_i(cmd_load_i),
    .cmd_i (cmd_i),
    .cmd_o (cmd_q)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    if (i == PWM_CH_A) begin : g_pwm_a
      assign req[i] = cmd_q[i] | pwm_s[0];
    end else if (i == PWM_CH_B) begin : g_pwm_b
      assign req[i] = cmd_q[i] | pwm_s[1];
    end else begin : g_plain
      assign req[i] = cmd_q[i];
    end

    og_channel u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req[i]),
      .therm_i (therm_s[i]),
      .permit_i(permit),
      .uv_i    (glob_s.undervolt),
      .drive_o (drive_o[i]),
      .flt_o   (otemp_flt_o[i])
    );
  end

  assert_en_low_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glob_s.enable |=> drive_o == '0);
  assert_ov_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glob_s.overvolt |=> drive_o == '0);
  assert_uv_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glob_s.undervolt |=> (drive_o == '0 && otemp_flt_o == '0));
  assert_reset_state_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (drive_o == '0 && otemp_flt_o == '0));
endmodule

// File: tb/tb_out_gate.sv
module tb_out_gate;
  localparam time HALF = 10ns;

  typedef struct {
    logic [7:0] drv;
    logic [7:0] flt;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cmd = '0;
  logic       load = 1'b0;
  logic [1:0] pwm = '0;
  logic       en = 1'b0;
  logic       ov = 1'b0;
  logic       uv = 1'b0;
  logic [7:0] therm = '0;
  logic [7:0] drive, flt;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #HALF clk = ~clk;

  out_gate dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cmd_i      (cmd),
    .cmd_load_i (load),
    .pwm_i      (pwm),
    .en_i       (en),
    .ov_i       (ov),
    .uv_i       (uv),
    .therm_i    (therm),
    .drive_o    (drive),
    .otemp_flt_o(flt)
  );

  // monitor: compare at falling edge, away from update edge
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (drive !== e.drv || flt !== e.flt) begin
          n_fail++;
          $display("FAIL %s: drive=%h flt=%h expected drive=%h flt=%h",
                   e.tag, drive, flt, e.drv, e.flt);
        end
      end
    end
  end

  task automatic chk(input int n, input logic [7:0] d, input logic [7:0] f, input string tag);
    repeat (n) @(posedge clk);
    #2;
    exp_q.push_back('{drv: d, flt: f, tag: tag});
  endtask

  task automatic load_cmd(input logic [7:0] v);
    @(negedge clk);
    cmd  = v;
    load = 1'b1;
    @(posedge clk);
    #2 load = 1'b0;
  endtask

  initial begin
    #(HALF * 2 * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    chk(0, 8'h00, 8'h00, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    en    = 1'b1;
    chk(1, 8'h00, 8'h00, "R1 after reset");
    repeat (4) @(posedge clk);

    // R2 / R10 command path latency
    load_cmd(8'hA5);
    chk(0, 8'h00, 8'h00, "R10 cmd not yet visible");
    chk(1, 8'hA5, 8'h00, "R2 R10 cmd A5");
    load_cmd(8'h3C);
    chk(2, 8'h3C, 8'h00, "R2 cmd 3C held");
    chk(3, 8'h3C, 8'h00, "R2 hold without load");

    // R3 direct inputs, R10 async latency
    load_cmd(8'h00);
    chk(2, 8'h00, 8'h00, "R2 cmd 00");
    @(negedge clk); pwm = 2'b01;
    chk(2, 8'h00, 8'h00, "R10 pwm not yet visible");
    chk(1, 8'h10, 8'h00, "R3 R10 pwm0 -> ch4");
    @(negedge clk); pwm = 2'b11;
    chk(3, 8'h30, 8'h00, "R3 both pwm");
    load_cmd(8'h10);
    @(negedge clk); pwm = 2'b10;
    chk(3, 8'h30, 8'h00, "R3 cmd ch4 OR pwm1 ch5");
    load_cmd(8'h00);
    chk(2, 8'h20, 8'h00, "R3 pwm1 only");
    @(negedge clk); pwm = 2'b00;
    chk(3, 8'h00, 8'h00, "R3 pwm released");

    // R4 enable
    load_cmd(8'h81);
    chk(2, 8'h81, 8'h00, "R2 cmd 81");
    @(negedge clk); en = 1'b0;
    chk(3, 8'h00, 8'h00, "R4 enable low");
    @(negedge clk); en = 1'b1;
    chk(3, 8'h81, 8'h00, "R4 enable restored");

    // R5 overvoltage with load inside window
    @(negedge clk); ov = 1'b1;
    chk(3, 8'h00, 8'h00, "R5 overvoltage off");
    load_cmd(8'h42);
    chk(3, 8'h00, 8'h00, "R5 load during ov stays off");
    @(negedge clk); ov = 1'b0;
    chk(3, 8'h42, 8'h00, "R5 resume new command");

    // R7 R8 R9 thermal
    load_cmd(8'hFF);
    chk(2, 8'hFF, 8'h00, "R2 cmd FF");
    @(negedge clk); therm = 8'h04;
    chk(3, 8'hFB, 8'h04, "R7 R9 ch2 thermal");
    @(negedge clk); therm = 8'h00;
    chk(3, 8'hFF, 8'h00, "R8 auto restart 1");
    @(negedge clk); therm = 8'h04;
    chk(3, 8'hFB, 8'h04, "R7 R9 ch2 thermal again");
    @(negedge clk); therm = 8'h00;
    chk(3, 8'hFF, 8'h00, "R8 auto restart 2");
    @(negedge clk); therm = 8'h04;
    chk(3, 8'hFB, 8'h04, "R7 thermal third");
    load_cmd(8'hFB);
    @(negedge clk); therm = 8'h00;
    chk(3, 8'hFB, 8'h00, "R8 cmd off no restart");
    load_cmd(8'h00);
    @(negedge clk); therm = 8'h01;
    chk(3, 8'h00, 8'h01, "R9 flag on idle channel");
    @(negedge clk); therm = 8'h00;
    chk(3, 8'h00, 8'h00, "R9 flag cleared");

    // R6 undervoltage
    load_cmd(8'h66);
    @(negedge clk); therm = 8'h80;
    chk(3, 8'h66, 8'h80, "R9 ch7 flag");
    @(negedge clk); uv = 1'b1; pwm = 2'b01;
    chk(3, 8'h00, 8'h00, "R6 uv all off, faults cleared");
    load_cmd(8'h0F);
    chk(3, 8'h00, 8'h00, "R6 load ignored in uv");
    @(negedge clk); uv = 1'b0; pwm = 2'b00;
    chk(3, 8'h00, 8'h80, "R6 cmd cleared after uv");
    @(negedge clk); therm = 8'h00; pwm = 2'b01;
    chk(3, 8'h10, 8'h00, "R6 R3 pwm after uv");
    @(negedge clk); pwm = 2'b00;
    load_cmd(8'h0F);
    chk(3, 8'h0F, 8'h00, "R6 new load after uv");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule